// File: doc/BRIEF.md
# I3C Target Address and Common-Command Engine

This block is the transaction-level core of an I3C target. It sits above a bit-level PHY and takes one byte-level bus event per clock. The events are a START or repeated START carrying a 7-bit address and a direction bit, a written byte, a read-byte request, a controller NACK and a STOP. For each START the core decides whether the target acknowledges.

The core holds the target's dynamic address. It takes part in dynamic address assignment and serves the common address-management and identity-query commands itself. All ordinary private traffic goes to a simple user data port. The static address, the 48-bit provisional ID, the bus-characteristics byte and the device-characteristics byte are configuration inputs.

Every response is registered. The acknowledge decision for a START, and the byte for a read request, appear on the outputs one clock after the event. A dynamic address of zero means that no dynamic address has been assigned.

Top module: `i3c_tgt_ccc_core`

## Requirements
- R1: After reset the dynamic address is 0 and addr_ack_valid, rd_valid, rd_unhandled, usr_wr_valid and usr_nack are low. The dynamic address changes only in the cycle after an accepted written byte.
- R2: While the dynamic address is 0 and no address-assignment phase is active, a START is acknowledged only for the static address or the broadcast address 7'h7E. addr_ack_valid pulses for one cycle, one clock after ev_start, and addr_ack carries the decision.
- R3: Once the dynamic address is nonzero, a START to the static address is refused and a START to the dynamic address is acknowledged.
- R4: Outside an address-assignment phase a broadcast START is always acknowledged and ends any command in progress. The first byte written after it is taken as the command code.
- R5: After command code 0x07 starts an address-assignment phase, a START is acknowledged only if its address is 7'h7E and the dynamic address is still 0. Any other address is refused.
- R6: In the address-assignment phase, successive read requests return 8 bytes in this order: the provisional ID least-significant byte first (6 bytes), then the bus-characteristics byte, then the device-characteristics byte. A byte offset advances by one on each of these bytes.
- R7: When the byte offset has reached 8, the next written byte sets the dynamic address to bits [6:0] of that byte, and the command state and offset clear. Later broadcast STOARTs in the same phase are refused.
- R8: Broadcast command 0x06 clears the dynamic address to 0.
- R9: Broadcast command 0x29 copies the static address into the dynamic address. Direct command 0x87 does the same on the first byte written to the target in its direct phase.
- R10: For direct command 0x88, the first byte written to the target after the command code sets the dynamic address to bits [6:0] of that byte. Later bytes in the same command are ignored.
- R11: Direct command 0x8D returns the 6 provisional ID bytes least-significant first. Direct command 0x8E returns the bus-characteristics byte, and direct command 0x8F returns the device-characteristics byte.
- R12: A read request under an unsupported command code, or past the end of the ID bytes, returns 0xFF with rd_unhandled high for that one cycle.
- R13: A STOP clears the command code, the byte offset, the in-command flag and the address-assignment phase. It keeps the dynamic address.
- R14: Outside any command, the target's own traffic is forwarded. A written byte pulses usr_wr_valid with the byte. A read request pulses usr_rd_req and returns usr_rd_data. A NACK pulses usr_nack. All of these appear one clock after the event. Bytes in an unselected transfer, or against the transfer direction, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_static_addr | input | 7 | Static address of the target |
| cfg_prov_id | input | 48 | Provisional ID |
| cfg_bus_char | input | 8 | Bus-characteristics byte |
| cfg_dev_char | input | 8 | Device-characteristics byte |
| ev_start | input | 1 | START or repeated START event |
| ev_addr | input | 7 | Address of the START |
| ev_rnw | input | 1 | Direction of the START, 1 = read |
| ev_wr | input | 1 | Written-byte event |
| ev_wdata | input | 8 | Written byte |
| ev_rd | input | 1 | Read-byte request |
| ev_nack | input | 1 | Controller NACK event |
| ev_stop | input | 1 | STOP event |
| addr_ack_valid | output | 1 | Address decision valid |
| addr_ack | output | 1 | 1 = address acknowledged |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| rd_unhandled | output | 1 | Read had no supported source |
| dyn_addr | output | 7 | Current dynamic address, 0 = none |
| usr_wr_valid | output | 1 | Private written byte valid |
| usr_wr_data | output | 8 | Private written byte |
| usr_rd_req | output | 1 | Private read request |
| usr_rd_data | input | 8 | Private read byte supplied by the user |
| usr_nack | output | 1 | Controller NACK in a private transfer |

## Verification
A wrong internal state shows at the ports in one of three ways. A lost or stuck in-command flag sends command bytes to the user port, or private bytes into the command path, on the next written byte. A stale byte offset returns ID bytes in the wrong order, or 0xFF too early, on the next read request. A stale address-assignment flag or a wrong dynamic address changes the addr_ack decision one clock after the next START. The scoreboard compares every acknowledge, read byte and forwarded byte, and checks the dynamic address after each address command. Most faults therefore appear within one event of the corruption.

// File: rtl/tgt_ccc_pkg.sv
package tgt_ccc_pkg;

    localparam int ADDR_W    = 7;
    localparam int BYTE_W    = 8;
    localparam int PID_BYTES = 6;
    localparam int PID_W     = PID_BYTES * BYTE_W;
    localparam int OFS_W     = $clog2(PID_BYTES + 3);

    localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;

    // offsets within the assignment reply
    localparam logic [OFS_W-1:0] OFS_BUS  = OFS_W'(PID_BYTES);
    localparam logic [OFS_W-1:0] OFS_DEV  = OFS_W'(PID_BYTES + 1);
    localparam logic [OFS_W-1:0] OFS_DONE = OFS_W'(PID_BYTES + 2);

    localparam logic [BYTE_W-1:0] CMD_DAA_ENTER   = 8'h07;
    localparam logic [BYTE_W-1:0] CMD_ADDR_RESET  = 8'h06;
    localparam logic [BYTE_W-1:0] CMD_ALL_STATIC  = 8'h29;
    localparam logic [BYTE_W-1:0] CMD_ONE_STATIC  = 8'h87;
    localparam logic [BYTE_W-1:0] CMD_SET_NEW     = 8'h88;
    localparam logic [BYTE_W-1:0] CMD_GET_ID      = 8'h8D;
    localparam logic [BYTE_W-1:0] CMD_GET_BUSCHAR = 8'h8E;
    localparam logic [BYTE_W-1:0] CMD_GET_DEVCHAR = 8'h8F;

    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef struct packed {
        logic [ADDR_W-1:0] dyn;
        logic              sel;
        logic              bcast;
        logic              rnw;
        logic              in_cmd;
        logic [BYTE_W-1:0] cmd;
        logic [OFS_W-1:0]  ofs;
        logic              daa;
        logic              ack_vld;
        logic              ack;
        logic              rd_vld;
        logic [BYTE_W-1:0] rdata;
        logic              unh;
        logic              priv_rd;
        logic              uwr_vld;
        logic [BYTE_W-1:0] uwr_data;
        logic              unack;
    } core_state_t;

endpackage

// File: rtl/tgt_addr_match.sv
module tgt_addr_match
    import tgt_ccc_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] own_static,
    input  logic [ADDR_W-1:0] own_dyn,
    input  logic              daa_active,
    output logic              hit,
    output logic              is_bcast
);
    logic [ADDR_W-1:0] own_addr;

    always_comb begin
        is_bcast = (bus_addr == BCAST_ADDR);
        own_addr = (own_dyn != '0) ? own_dyn : own_static;
        if (daa_active) begin
            hit = is_bcast && (own_dyn == '0);
        end else if (is_bcast) begin
            hit = 1'b1;
        end else begin
            hit = (bus_addr == own_addr);
        end
    end
endmodule

// File: rtl/tgt_ccc_read_mux.sv
module tgt_ccc_read_mux
    import tgt_ccc_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [PID_W-1:0]  prov_id,
    input  logic [BYTE_W-1:0] bus_char,
    input  logic [BYTE_W-1:0] dev_char,
    output logic [BYTE_W-1:0] byte_o,
    output logic              unh,
    output logic              adv
);
    logic [BYTE_W-1:0] id_byte [PID_BYTES];
    logic [BYTE_W-1:0] id_sel;
    logic              id_left;

    for (genvar i = 0; i < PID_BYTES; i++) begin : g_idb
        assign id_byte[i] = prov_id[i*BYTE_W +: BYTE_W];
    end

    always_comb begin
        id_sel = IDLE_BYTE;
        for (int i = 0; i < PID_BYTES; i++) begin
            if (ofs == OFS_W'(i)) id_sel = id_byte[i];
        end
        id_left = (ofs < OFS_BUS);
    end

    always_comb begin
        byte_o = IDLE_BYTE;
        unh    = 1'b0;
        adv    = 1'b0;
        case (cmd)
            CMD_DAA_ENTER: begin
                if (id_left) begin
                    byte_o = id_sel;
                    adv    = 1'b1;
                end else if (ofs == OFS_BUS) begin
                    byte_o = bus_char;
                    adv    = 1'b1;
                end else if (ofs == OFS_DEV) begin
                    byte_o = dev_char;
                    adv    = 1'b1;
                end else begin
                    unh = 1'b1;
                end
            end
            CMD_GET_ID: begin
                if (id_left) begin
                    byte_o = id_sel;
                    adv    = 1'b1;
                end else begin
                    unh = 1'b1;
                end
            end
            CMD_GET_BUSCHAR: byte_o = bus_char;
            CMD_GET_DEVCHAR: byte_o = dev_char;
            default:         unh = 1'b1;
        endcase
    end
endmodule

// File: rtl/i3c_tgt_ccc_core.sv
module i3c_tgt_ccc_core
    import tgt_ccc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_static_addr,
    input  logic [PID_W-1:0]  cfg_prov_id,
    input  logic [BYTE_W-1:0] cfg_bus_char,
    input  logic [BYTE_W-1:0] cfg_dev_char,
    input  logic              ev_start,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_rnw,
    input  logic              ev_wr,
    input  logic [BYTE_W-1:0] ev_wdata,
    input  logic              ev_rd,
    input  logic              ev_nack,
    input  logic              ev_stop,
    output logic              addr_ack_valid,
    output logic              addr_ack,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_unhandled,
    output logic [ADDR_W-1:0] dyn_addr,
    output logic              usr_wr_valid,
    output logic [BYTE_W-1:0] usr_wr_data,
    output logic              usr_rd_req,
    input  logic [BYTE_W-1:0] usr_rd_data,
    output logic              usr_nack
);
    core_state_t st_q, st_d;

    logic              m_hit, m_bcast;
    logic [BYTE_W-1:0] r_byte;
    logic              r_unh, r_adv;

    // views of the state for the bound checker
    logic              in_daa;
    logic              in_cmd;
    logic [OFS_W-1:0]  byte_ofs;
    assign in_daa   = st_q.daa;
    assign in_cmd   = st_q.in_cmd;
    assign byte_ofs = st_q.ofs;

    tgt_addr_match u_match (
        .bus_addr   (ev_addr),
        .own_static (cfg_static_addr),
        .own_dyn    (st_q.dyn),
        .daa_active (st_q.daa),
        .hit        (m_hit),
        .is_bcast   (m_bcast)
    );

    tgt_ccc_read_mux u_rmux (
        .cmd      (st_q.cmd),
        .ofs      (st_q.ofs),
        .prov_id  (cfg_prov_id),
        .bus_char (cfg_bus_char),
        .dev_char (cfg_dev_char),
        .byte_o   (r_byte),
        .unh      (r_unh),
        .adv      (r_adv)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ack_vld = 1'b0;
        st_d.rd_vld  = 1'b0;
        st_d.unh     = 1'b0;
        st_d.priv_rd = 1'b0;
        st_d.uwr_vld = 1'b0;
        st_d.unack   = 1'b0;

        if (ev_stop) begin
            st_d.sel    = 1'b0;
            st_d.bcast  = 1'b0;
            st_d.in_cmd = 1'b0;
            st_d.cmd    = '0;
            st_d.ofs    = '0;
            st_d.daa    = 1'b0;
        end else if (ev_start) begin
            st_d.ack_vld = 1'b1;
            st_d.ack     = m_hit;
            st_d.sel     = m_hit;
            st_d.rnw     = ev_rnw;
            st_d.bcast   = m_bcast;
            if (m_bcast && !st_q.daa) begin
                st_d.in_cmd = 1'b0;
                st_d.cmd    = '0;
                st_d.ofs    = '0;
            end
        end else if (ev_wr && st_q.sel && !st_q.rnw) begin
            if (st_q.bcast && !st_q.in_cmd) begin
                st_d.cmd    = ev_wdata;
                st_d.in_cmd = 1'b1;
                st_d.ofs    = '0;
                case (ev_wdata)
                    CMD_DAA_ENTER:  st_d.daa = 1'b1;
                    CMD_ADDR_RESET: st_d.dyn = '0;
                    CMD_ALL_STATIC: st_d.dyn = cfg_static_addr;
                    default: ;
                endcase
            end else if (st_q.in_cmd && st_q.cmd == CMD_DAA_ENTER) begin
                if (st_q.ofs == OFS_DONE) begin
                    st_d.dyn    = ev_wdata[ADDR_W-1:0];
                    st_d.in_cmd = 1'b0;
                    st_d.cmd    = '0;
                    st_d.ofs    = '0;
                end
            end else if (st_q.in_cmd && !st_q.bcast) begin
                if (st_q.ofs == '0) begin
                    case (st_q.cmd)
                        CMD_ONE_STATIC: begin
                            st_d.dyn = cfg_static_addr;
                            st_d.ofs = OFS_W'(1);
                        end
                        CMD_SET_NEW: begin
                            st_d.dyn = ev_wdata[ADDR_W-1:0];
                            st_d.ofs = OFS_W'(1);
                        end
                        default: ;
                    endcase
                end
            end else if (!st_q.in_cmd && !st_q.bcast) begin
                st_d.uwr_vld  = 1'b1;
                st_d.uwr_data = ev_wdata;
            end
        end else if (ev_rd && st_q.sel && st_q.rnw) begin
            st_d.rd_vld = 1'b1;
            if (st_q.in_cmd) begin
                st_d.rdata = r_byte;
                st_d.unh   = r_unh;
                if (r_adv) st_d.ofs = st_q.ofs + OFS_W'(1);
            end else if (st_q.bcast) begin
                st_d.rdata = IDLE_BYTE;
                st_d.unh   = 1'b1;
            end else begin
                st_d.priv_rd = 1'b1;
            end
        end else if (ev_nack && st_q.sel && !st_q.in_cmd && !st_q.bcast) begin
            st_d.unack = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_ack_valid = st_q.ack_vld;
    assign addr_ack       = st_q.ack;
    assign rd_valid       = st_q.rd_vld;
    assign rd_data        = st_q.priv_rd ? usr_rd_data : st_q.rdata;
    assign rd_unhandled   = st_q.unh;
    assign dyn_addr       = st_q.dyn;
    assign usr_wr_valid   = st_q.uwr_vld;
    assign usr_wr_data    = st_q.uwr_data;
    assign usr_rd_req     = st_q.priv_rd;
    assign usr_nack       = st_q.unack;
endmodule

// File: rtl/i3c_tgt_ccc_chk.sv
module i3c_tgt_ccc_chk
    import tgt_ccc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ev_start,
    input logic [ADDR_W-1:0] ev_addr,
    input logic              ev_wr,
    input logic              ev_rd,
    input logic              ev_stop,
    input logic              addr_ack_valid,
    input logic              addr_ack,
    input logic              rd_valid,
    input logic [BYTE_W-1:0] rd_data,
    input logic              rd_unhandled,
    input logic [ADDR_W-1:0] dyn_addr,
    input logic              usr_rd_req,
    input logic              in_daa,
    input logic              in_cmd,
    input logic [OFS_W-1:0]  byte_ofs
);
    a_r1_dyn_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_wr |=> $stable(dyn_addr));

    a_r2_ack_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_stop) |=> addr_ack_valid);

    a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_start |=> !addr_ack_valid);

    a_r5_daa_refuse_assigned: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_stop && in_daa && dyn_addr != '0) |=> !addr_ack);

    a_r5_daa_refuse_other: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_stop && in_daa && ev_addr != BCAST_ADDR) |=> !addr_ack);

    a_r6_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ofs <= OFS_DONE);

    a_r12_unhandled_ff: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unhandled |-> (rd_valid && rd_data == IDLE_BYTE));

    a_r13_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (!in_cmd && byte_ofs == '0 && !in_daa));

    a_r14_read_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_rd |=> !rd_valid);

    a_r14_user_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        usr_rd_req |-> (rd_valid && !rd_unhandled));
endmodule

bind i3c_tgt_ccc_core i3c_tgt_ccc_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_start       (ev_start),
    .ev_addr        (ev_addr),
    .ev_wr          (ev_wr),
    .ev_rd          (ev_rd),
    .ev_stop        (ev_stop),
    .addr_ack_valid (addr_ack_valid),
    .addr_ack       (addr_ack),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .rd_unhandled   (rd_unhandled),
    .dyn_addr       (dyn_addr),
    .usr_rd_req     (usr_rd_req),
    .in_daa         (in_daa),
    .in_cmd         (in_cmd),
    .byte_ofs       (byte_ofs)
);

// File: tb/i3c_tgt_ccc_core_tb.sv
module i3c_tgt_ccc_core_tb;
    import tgt_ccc_pkg::*;

    localparam logic [6:0]  STAT = 7'h2A;
    localparam logic [47:0] PID  = 48'hA1B2C3D4E5F6;
    localparam logic [7:0]  BUSC = 8'h66;
    localparam logic [7:0]  DEVC = 8'h44;
    localparam logic [7:0]  URD  = 8'h5C;

    localparam int K_ACK = 0, K_RD = 1, K_UWR = 2, K_NACK = 3;

    typedef struct {
        int         kind;
        logic [7:0] data;
        logic       unh;
        string      req;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic ev_start = 0, ev_rnw = 0, ev_wr = 0, ev_rd = 0, ev_nack = 0, ev_stop = 0;
    logic [6:0] ev_addr = '0;
    logic [7:0] ev_wdata = '0;
    logic addr_ack_valid, addr_ack, rd_valid, rd_unhandled, usr_wr_valid, usr_rd_req, usr_nack;
    logic [7:0] rd_data, usr_wr_data;
    logic [6:0] dyn_addr;

    int checks = 0, fails = 0;
    bit done = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    i3c_tgt_ccc_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_static_addr(STAT), .cfg_prov_id(PID),
        .cfg_bus_char(BUSC), .cfg_dev_char(DEVC),
        .ev_start(ev_start), .ev_addr(ev_addr), .ev_rnw(ev_rnw),
        .ev_wr(ev_wr), .ev_wdata(ev_wdata), .ev_rd(ev_rd),
        .ev_nack(ev_nack), .ev_stop(ev_stop),
        .addr_ack_valid(addr_ack_valid), .addr_ack(addr_ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_unhandled(rd_unhandled),
        .dyn_addr(dyn_addr),
        .usr_wr_valid(usr_wr_valid), .usr_wr_data(usr_wr_data),
        .usr_rd_req(usr_rd_req), .usr_rd_data(URD), .usr_nack(usr_nack)
    );

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic void push(int kind, logic [7:0] d, logic u, string req);
        exp_t e;
        e.kind = kind; e.data = d; e.unh = u; e.req = req;
        exp_q.push_back(e);
    endfunction

    // monitor: pop and compare each observed response
    always @(negedge clk) begin
        if (rst_n) begin
            int kind;
            logic [7:0] d;
            logic u;
            bit seen;
            seen = 1'b1; u = 1'b0; kind = 0; d = '0;
            if (addr_ack_valid)    begin kind = K_ACK;  d = {7'd0, addr_ack}; end
            else if (rd_valid)     begin kind = K_RD;   d = rd_data; u = rd_unhandled; end
            else if (usr_wr_valid) begin kind = K_UWR;  d = usr_wr_data; end
            else if (usr_nack)     begin kind = K_NACK; end
            else seen = 1'b0;
            if (seen) begin
                if (exp_q.size() == 0) begin
                    check(0, "R14", "unexpected output kind", 64'(kind), 64'hF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(kind == e.kind && d == e.data && u == e.unh, e.req,
                          "response {kind,data,unh}",
                          {32'(kind), 16'(d), 8'(u)}, {32'(e.kind), 16'(e.data), 8'(e.unh)});
                end
            end
        end
    end

    task automatic do_start(logic [6:0] a, logic rnw, logic exp_ack, string req);
        push(K_ACK, {7'd0, exp_ack}, 1'b0, req);
        @(negedge clk); ev_start = 1; ev_addr = a; ev_rnw = rnw;
        @(negedge clk); ev_start = 0;
    endtask

    task automatic do_wr(logic [7:0] d, bit fwd, string req);
        if (fwd) push(K_UWR, d, 1'b0, req);
        @(negedge clk); ev_wr = 1; ev_wdata = d;
        @(negedge clk); ev_wr = 0;
    endtask

    task automatic do_rd(bit resp, logic [7:0] d, logic u, string req);
        if (resp) push(K_RD, d, u, req);
        @(negedge clk); ev_rd = 1;
        @(negedge clk); ev_rd = 0;
    endtask

    task automatic do_nack(bit resp, string req);
        if (resp) push(K_NACK, 8'd0, 1'b0, req);
        @(negedge clk); ev_nack = 1;
        @(negedge clk); ev_nack = 0;
    endtask

    task automatic do_stop();
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0;
    endtask

    task automatic chk_dyn(logic [6:0] expv, string req);
        @(negedge clk);
        check(dyn_addr == expv, req, "dyn_addr", 64'(dyn_addr), 64'(expv));
    endtask

    task automatic bcast_cmd(logic [7:0] code, string req);
        do_start(BCAST_ADDR, 0, 1, req);
        do_wr(code, 0, req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check(0, "R1", "watchdog expired", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(dyn_addr == 0, "R1", "reset dyn_addr", 64'(dyn_addr), 0);
        check(!addr_ack_valid && !rd_valid && !usr_wr_valid && !usr_nack && !rd_unhandled,
              "R1", "reset outputs idle", 64'({addr_ack_valid, rd_valid, usr_wr_valid}), 0);

        // R2 static match while unassigned
        do_start(STAT, 0, 1, "R2");
        do_start(7'h33, 0, 0, "R2");
        do_start(BCAST_ADDR, 0, 1, "R4");
        do_stop();

        // R14 private traffic
        do_start(STAT, 0, 1, "R14");
        do_wr(8'h11, 1, "R14");
        do_rd(0, 8'h00, 0, "R14");        // against direction: no output
        do_start(STAT, 1, 1, "R14");
        do_rd(1, URD, 0, "R14");
        do_nack(1, "R14");
        do_stop();
        do_start(7'h33, 0, 0, "R14");
        do_wr(8'h22, 0, "R14");
        do_rd(0, 8'h00, 0, "R14");
        do_stop();

        // R10 direct set-new-address
        bcast_cmd(CMD_SET_NEW, "R10");
        do_start(STAT, 0, 1, "R10");
        do_wr(8'h35, 0, "R10");
        do_wr(8'h40, 0, "R10");
        do_stop();
        chk_dyn(7'h35, "R10");

        // R3 only dynamic address now
        do_start(STAT, 0, 0, "R3");
        do_start(7'h35, 0, 1, "R3");
        do_stop();

        // R11 identity queries
        bcast_cmd(CMD_GET_ID, "R11");
        do_start(7'h35, 1, 1, "R11");
        do_rd(1, 8'hF6, 0, "R11");
        do_rd(1, 8'hE5, 0, "R11");
        do_rd(1, 8'hD4, 0, "R11");
        do_rd(1, 8'hC3, 0, "R11");
        do_rd(1, 8'hB2, 0, "R11");
        do_rd(1, 8'hA1, 0, "R11");
        do_rd(1, 8'hFF, 1, "R12");
        bcast_cmd(CMD_GET_BUSCHAR, "R11");
        do_start(7'h35, 1, 1, "R11");
        do_rd(1, BUSC, 0, "R11");
        bcast_cmd(CMD_GET_DEVCHAR, "R11");
        do_start(7'h35, 1, 1, "R11");
        do_rd(1, DEVC, 0, "R11");
        do_stop();

        // R12 unsupported code
        bcast_cmd(8'h90, "R12");
        do_start(7'h35, 1, 1, "R12");
        do_rd(1, 8'hFF, 1, "R12");
        do_stop();

        // R8 address reset
        bcast_cmd(CMD_ADDR_RESET, "R8");
        do_stop();
        chk_dyn(7'h00, "R8");

        // R5 R6 R7 dynamic assignment
        bcast_cmd(CMD_DAA_ENTER, "R5");
        do_start(STAT, 0, 0, "R5");
        do_start(BCAST_ADDR, 1, 1, "R5");
        do_rd(1, 8'hF6, 0, "R6");
        do_rd(1, 8'hE5, 0, "R6");
        do_rd(1, 8'hD4, 0, "R6");
        do_rd(1, 8'hC3, 0, "R6");
        do_rd(1, 8'hB2, 0, "R6");
        do_rd(1, 8'hA1, 0, "R6");
        do_rd(1, BUSC, 0, "R6");
        do_rd(1, DEVC, 0, "R6");
        do_start(BCAST_ADDR, 0, 1, "R7");
        do_wr(8'h51, 0, "R7");
        do_start(BCAST_ADDR, 1, 0, "R7");
        do_stop();
        chk_dyn(7'h51, "R7");

        // R13 stop ends command; later traffic is private
        bcast_cmd(CMD_GET_BUSCHAR, "R13");
        do_stop();
        do_start(7'h51, 0, 1, "R13");
        do_wr(8'h77, 1, "R13");
        do_stop();

        // R9 assign from static, both forms
        bcast_cmd(CMD_ADDR_RESET, "R9");
        do_stop();
        chk_dyn(7'h00, "R9");
        bcast_cmd(CMD_ONE_STATIC, "R9");
        do_start(STAT, 0, 1, "R9");
        do_wr(8'h00, 0, "R9");
        do_stop();
        chk_dyn(STAT, "R9");
        bcast_cmd(CMD_ADDR_RESET, "R9");
        do_stop();
        bcast_cmd(CMD_ALL_STATIC, "R9");
        do_stop();
        chk_dyn(STAT, "R9");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R14", "responses outstanding", 64'(exp_q.size()), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule